// File: doc/BRIEF.md
# Register Wakeup and Scoreboard Unit

This block tracks which physical registers hold valid results and which waiting consumers depend on each one. A completing producer presents up to `MAX_DST` renamed destination registers. The unit handles them one slot at a time. For each slot it drains the consumer list of that register, and each list entry lowers its consumer's outstanding-source count by one. Once the list is empty, the unit sets the register's scoreboard bit. A destination index that lies outside the physical file is skipped. A wake carries no source identity: it only lowers the count.

Consumers are registered one source per cycle. The first registration of a consumer loads its source count. A source whose register is already ready lowers the count at once and takes no list entry. Any other source is pushed onto the head of that register's list, which lives in a shared pool of link entries. A consumer whose count reaches zero is queued once on a valid/ready output stream. While a walk is in progress, `busy` stays high, and every completion, allocation and registration presented during that time is dropped.

Top module: `wk_wakeup_unit`

## Requirements
- R1: After reset every scoreboard bit is 1 (ready), `busy` is 0 and `rdy_valid` is 0.
- R2: An accepted allocation with `alc_preg` below `NUM_PREGS` clears that scoreboard bit and leaves all other bits alone. An index at or above `NUM_PREGS` changes nothing.
- R3: A completion is accepted when `cmp_valid` is high and `busy` is low, and `busy` is high in the next cycle. While `busy` is high, any completion, allocation or registration presented is ignored.
- R4: A destination slot whose `cmp_dst_vld` bit is 0, or whose index is at or above `NUM_PREGS`, does not change the scoreboard. Slot i occupies bits `[i*IDX_W +: IDX_W]` of `cmp_dst`.
- R5: Each list entry recorded against a completed register lowers its consumer's count by one. A consumer whose count reaches zero becomes pending on the output.
- R6: After the last list entry of a register has been consumed, that register's scoreboard bit is set and its list is empty. A later completion of the same register wakes no one.
- R7: A registration whose source register is ready (bit 1, or an index at or above `NUM_PREGS`) lowers the count in the same cycle and adds no list entry.
- R8: `reg_first`=1 loads `reg_nsrc` as the count before this source is applied. A consumer with two sources is not emitted until both are woken, including two sources on the same register.
- R9: Each consumer that reaches zero is presented exactly once. `rdy_valid` stays high until `rdy_ready`, and when several consumers are pending the lowest identifier goes first.
- R10: A walk takes one cycle per linked entry plus one cycle per slot (to set the bit, or to skip). `busy` is high for exactly that many cycles after acceptance.
- R11: A registration that names the register being allocated in the same cycle treats that source as not ready and links it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alc_valid | input | 1 | Mark a register as awaiting a result |
| alc_preg | input | IDX_W | Register being allocated |
| cmp_valid | input | 1 | Producer completion present |
| cmp_dst | input | MAX_DST*IDX_W | Destination register indices, slot 0 in the low bits |
| cmp_dst_vld | input | MAX_DST | Per-slot valid |
| reg_valid | input | 1 | Consumer source registration present |
| reg_cons | input | CW | Consumer identifier |
| reg_first | input | 1 | First source of this consumer; load count |
| reg_nsrc | input | CNT_W | Number of sources (used when `reg_first`) |
| reg_preg | input | IDX_W | Source register of this registration |
| busy | output | 1 | Walk in progress; inputs ignored |
| rdy_valid | output | 1 | A consumer is ready to issue |
| rdy_ready | input | 1 | Downstream accepts `rdy_cons` |
| rdy_cons | output | CW | Identifier of the ready consumer |
| sb_rdy | output | NUM_PREGS | Scoreboard, one ready bit per register |

## Verification
The bound checker checks these properties on every cycle:
- an accepted completion raises `busy`;
- a skipped slot leaves the scoreboard unchanged;
- each list pop returns exactly one pool entry;
- a count reaching zero raises `rdy_valid`;
- an unaccepted output stays valid.

Only the bench scenarios show the end-to-end results:
- the exact walk lengths;
- the set of consumers emitted after multi-source and same-register dependencies;
- that a drained list stays empty;
- that inputs presented while busy, or against an already-ready register, leave the scoreboard and the emitted set as the requirements predict.

// File: rtl/wk_pkg.sv
package wk_pkg;

  typedef enum logic [0:0] {
    WK_IDLE = 1'b0,
    WK_WALK = 1'b1
  } wk_state_e;

  // Outstanding-source arithmetic: a wake removes one source.
  function automatic int unsigned cnt_step(input int unsigned base, input bit dec);
    return dec ? base - 1 : base;
  endfunction

endpackage

// File: rtl/wk_scoreboard.sv
module wk_scoreboard #(
  parameter int NUM_PREGS = 16,
  parameter int IDX_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic                 set_en,
  input  logic [IDX_W-1:0]     set_idx,
  output logic [NUM_PREGS-1:0] ready_vec
);

  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ready_vec[g] <= 1'b1;
      end else if (set_en && set_idx == IDX_W'(g)) begin
        ready_vec[g] <= 1'b1;
      end else if (clr_en && clr_idx == IDX_W'(g)) begin
        ready_vec[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wk_dep_pool.sv
module wk_dep_pool #(
  parameter int NUM_PREGS = 16,
  parameter int POOL      = 16,
  parameter int CW        = 3,
  localparam int PREG_W   = $clog2(NUM_PREGS),
  localparam int PTR_W    = (POOL > 1) ? $clog2(POOL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [PREG_W-1:0] push_preg,
  input  logic [CW-1:0]     push_cons,
  input  logic              pop_en,
  input  logic [PREG_W-1:0] q_preg,
  output logic              q_has,
  output logic [CW-1:0]     q_cons,
  output logic [POOL-1:0]   free_vec
);

  logic [NUM_PREGS-1:0] head_vld;
  logic [PTR_W-1:0]     head_ptr [NUM_PREGS];
  logic [CW-1:0]        ent_cons [POOL];
  logic [PTR_W-1:0]     ent_nxt  [POOL];
  logic [POOL-1:0]      ent_nxt_vld;
  logic [PTR_W-1:0]     alloc_ptr;
  logic [PTR_W-1:0]     pop_ptr;

  // Lowest free entry.
  always_comb begin
    alloc_ptr = '0;
    for (int i = POOL - 1; i >= 0; i--) begin
      if (free_vec[i]) alloc_ptr = PTR_W'(i);
    end
  end

  assign pop_ptr = head_ptr[q_preg];
  assign q_has   = head_vld[q_preg];
  assign q_cons  = ent_cons[pop_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_vld    <= '0;
      free_vec    <= '1;
      ent_nxt_vld <= '0;
      for (int i = 0; i < NUM_PREGS; i++) head_ptr[i] <= '0;
      for (int i = 0; i < POOL; i++) begin
        ent_cons[i] <= '0;
        ent_nxt[i]  <= '0;
      end
    end else if (push_en) begin
      ent_cons[alloc_ptr]    <= push_cons;
      ent_nxt[alloc_ptr]     <= head_ptr[push_preg];
      ent_nxt_vld[alloc_ptr] <= head_vld[push_preg];
      head_ptr[push_preg]    <= alloc_ptr;
      head_vld[push_preg]    <= 1'b1;
      free_vec[alloc_ptr]    <= 1'b0;
    end else if (pop_en) begin
      head_ptr[q_preg]  <= ent_nxt[pop_ptr];
      head_vld[q_preg]  <= ent_nxt_vld[pop_ptr];
      free_vec[pop_ptr] <= 1'b1;
    end
  end

endmodule

// File: rtl/wk_src_count.sv
module wk_src_count
  import wk_pkg::*;
#(
  parameter int NUM_CONS = 8,
  parameter int CNT_W    = 2,
  localparam int CW      = (NUM_CONS > 1) ? $clog2(NUM_CONS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [CW-1:0]    upd_id,
  input  logic             upd_first,
  input  logic [CNT_W-1:0] upd_load,
  input  logic             upd_dec,
  input  logic             rdy_ready,
  output logic             rdy_valid,
  output logic [CW-1:0]    rdy_cons,
  output logic             zero_evt
);

  logic [CNT_W-1:0]    cnt_q [NUM_CONS];
  logic [NUM_CONS-1:0] pend_q;
  logic [CNT_W-1:0]    base;
  logic [CNT_W-1:0]    nxt;
  logic                hs;

  assign base     = upd_first ? upd_load : cnt_q[upd_id];
  assign nxt      = CNT_W'(cnt_step(32'(base), upd_dec));
  assign zero_evt = upd_en && upd_dec && (nxt == '0);
  assign hs       = rdy_valid && rdy_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CONS; i++) cnt_q[i] <= '0;
    end else if (upd_en) begin
      cnt_q[upd_id] <= nxt;
    end
  end

  for (genvar g = 0; g < NUM_CONS; g++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
      end else if (zero_evt && upd_id == CW'(g)) begin
        pend_q[g] <= 1'b1;
      end else if (hs && rdy_cons == CW'(g)) begin
        pend_q[g] <= 1'b0;
      end
    end
  end

  // Lowest pending identifier is offered first.
  always_comb begin
    rdy_cons = '0;
    for (int i = NUM_CONS - 1; i >= 0; i--) begin
      if (pend_q[i]) rdy_cons = CW'(i);
    end
  end
  assign rdy_valid = |pend_q;

endmodule

// File: rtl/wk_wakeup_unit.sv
module wk_wakeup_unit
  import wk_pkg::*;
#(
  parameter int NUM_PREGS = 16,
  parameter int NUM_CONS  = 8,
  parameter int MAX_SRC   = 2,
  parameter int MAX_DST   = 2,
  localparam int PREG_W   = $clog2(NUM_PREGS),
  localparam int IDX_W    = PREG_W + 1,
  localparam int CW       = (NUM_CONS > 1) ? $clog2(NUM_CONS) : 1,
  localparam int CNT_W    = $clog2(MAX_SRC + 1),
  localparam int POOL     = NUM_CONS * MAX_SRC,
  localparam int SLOT_W   = (MAX_DST > 1) ? $clog2(MAX_DST) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alc_valid,
  input  logic [IDX_W-1:0]         alc_preg,
  input  logic                     cmp_valid,
  input  logic [MAX_DST*IDX_W-1:0] cmp_dst,
  input  logic [MAX_DST-1:0]       cmp_dst_vld,
  input  logic                     reg_valid,
  input  logic [CW-1:0]            reg_cons,
  input  logic                     reg_first,
  input  logic [CNT_W-1:0]         reg_nsrc,
  input  logic [IDX_W-1:0]         reg_preg,
  output logic                     busy,
  output logic                     rdy_valid,
  input  logic                     rdy_ready,
  output logic [CW-1:0]            rdy_cons,
  output logic [NUM_PREGS-1:0]     sb_rdy
);

  wk_state_e          state_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [IDX_W-1:0]   dst_q [MAX_DST];
  logic [MAX_DST-1:0] dvld_q;

  // Named internal events, observed by the checker.
  logic             cmp_acc, reg_acc, alc_acc;
  logic             walk_skip, walk_pop, walk_set;
  logic             cur_in, slot_done, last_slot;
  logic [IDX_W-1:0] cur_idx;
  logic             q_has;
  logic [CW-1:0]    q_cons;
  logic [POOL-1:0]  free_vec;
  logic             zero_evt;
  logic             src_ready, reg_in, alc_hit;

  assign busy    = (state_q == WK_WALK);
  assign cmp_acc = cmp_valid && !busy;
  assign reg_acc = reg_valid && !busy;
  assign alc_acc = alc_valid && !busy;

  assign cur_idx   = dst_q[slot_q];
  assign cur_in    = dvld_q[slot_q] && (cur_idx < IDX_W'(NUM_PREGS));
  assign walk_skip = busy && !cur_in;
  assign walk_pop  = busy && cur_in && q_has;
  assign walk_set  = busy && cur_in && !q_has;
  assign slot_done = walk_skip || walk_set;
  assign last_slot = (slot_q == SLOT_W'(MAX_DST - 1));

  // A source under allocation this cycle is not ready.
  assign reg_in    = (reg_preg < IDX_W'(NUM_PREGS));
  assign alc_hit   = alc_acc && (alc_preg == reg_preg);
  assign src_ready = !reg_in || (sb_rdy[reg_preg[PREG_W-1:0]] && !alc_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      slot_q  <= '0;
      dvld_q  <= '0;
      for (int i = 0; i < MAX_DST; i++) dst_q[i] <= '0;
    end else if (!busy) begin
      if (cmp_acc) begin
        state_q <= WK_WALK;
        slot_q  <= '0;
        dvld_q  <= cmp_dst_vld;
        for (int i = 0; i < MAX_DST; i++) dst_q[i] <= cmp_dst[i*IDX_W +: IDX_W];
      end
    end else if (slot_done) begin
      if (last_slot) begin
        state_q <= WK_IDLE;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  wk_scoreboard #(
    .NUM_PREGS (NUM_PREGS),
    .IDX_W     (IDX_W)
  ) u_sb (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_en    (alc_acc && (alc_preg < IDX_W'(NUM_PREGS))),
    .clr_idx   (alc_preg),
    .set_en    (walk_set),
    .set_idx   (cur_idx),
    .ready_vec (sb_rdy)
  );

  wk_dep_pool #(
    .NUM_PREGS (NUM_PREGS),
    .POOL      (POOL),
    .CW        (CW)
  ) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (reg_acc && !src_ready),
    .push_preg (reg_preg[PREG_W-1:0]),
    .push_cons (reg_cons),
    .pop_en    (walk_pop),
    .q_preg    (cur_idx[PREG_W-1:0]),
    .q_has     (q_has),
    .q_cons    (q_cons),
    .free_vec  (free_vec)
  );

  wk_src_count #(
    .NUM_CONS  (NUM_CONS),
    .CNT_W     (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (reg_acc || walk_pop),
    .upd_id    (walk_pop ? q_cons : reg_cons),
    .upd_first (reg_acc && reg_first),
    .upd_load  (reg_nsrc),
    .upd_dec   (walk_pop || src_ready),
    .rdy_ready (rdy_ready),
    .rdy_valid (rdy_valid),
    .rdy_cons  (rdy_cons),
    .zero_evt  (zero_evt)
  );

endmodule

// File: rtl/wk_wakeup_chk.sv
module wk_wakeup_chk #(
  parameter int NUM_PREGS = 16,
  parameter int POOL      = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 cmp_acc,
  input logic                 walk_skip,
  input logic                 walk_pop,
  input logic [NUM_PREGS-1:0] sb_rdy,
  input logic [POOL-1:0]      free_vec,
  input logic                 zero_evt,
  input logic                 rdy_valid,
  input logic                 rdy_ready
);

  p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_acc |=> busy);

  p_skip_keeps_sb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_skip |=> $stable(sb_rdy));

  p_zero_emits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> rdy_valid);

  p_hold_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_valid && !rdy_ready) |=> rdy_valid);

  p_pop_frees_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    walk_pop |=> ($countones(free_vec) == $past($countones(free_vec)) + 1));

endmodule

bind wk_wakeup_unit wk_wakeup_chk #(
  .NUM_PREGS (NUM_PREGS),
  .POOL      (POOL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .cmp_acc   (cmp_acc),
  .walk_skip (walk_skip),
  .walk_pop  (walk_pop),
  .sb_rdy    (sb_rdy),
  .free_vec  (free_vec),
  .zero_evt  (zero_evt),
  .rdy_valid (rdy_valid),
  .rdy_ready (rdy_ready)
);

// File: tb/tb_wk_wakeup_unit.sv
`timescale 1ns/1ps
module tb_wk_wakeup_unit;

  localparam int NP = 16;
  localparam int IW = 5;
  localparam int CWB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alc_valid = 1'b0;
  logic [IW-1:0] alc_preg = '0;
  logic cmp_valid = 1'b0;
  logic [2*IW-1:0] cmp_dst = '0;
  logic [1:0] cmp_dst_vld = '0;
  logic reg_valid = 1'b0;
  logic [CWB-1:0] reg_cons = '0;
  logic reg_first = 1'b0;
  logic [1:0] reg_nsrc = '0;
  logic [IW-1:0] reg_preg = '0;
  logic busy, rdy_valid;
  logic rdy_ready = 1'b0;
  logic [CWB-1:0] rdy_cons;
  logic [NP-1:0] sb_rdy;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wk_wakeup_unit dut (
    .clk(clk), .rst_n(rst_n),
    .alc_valid(alc_valid), .alc_preg(alc_preg),
    .cmp_valid(cmp_valid), .cmp_dst(cmp_dst), .cmp_dst_vld(cmp_dst_vld),
    .reg_valid(reg_valid), .reg_cons(reg_cons), .reg_first(reg_first),
    .reg_nsrc(reg_nsrc), .reg_preg(reg_preg),
    .busy(busy), .rdy_valid(rdy_valid), .rdy_ready(rdy_ready),
    .rdy_cons(rdy_cons), .sb_rdy(sb_rdy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_alloc(input int p);
    alc_valid = 1'b1; alc_preg = IW'(p);
    @(negedge clk);
    alc_valid = 1'b0;
  endtask

  task automatic do_reg(input int c, input bit first, input int n, input int p);
    reg_valid = 1'b1; reg_cons = CWB'(c); reg_first = first;
    reg_nsrc = 2'(n); reg_preg = IW'(p);
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  // Completion; returns the number of cycles busy stays high.
  task automatic do_cmp(input int d0, input bit v0, input int d1, input bit v1, output int cyc);
    cmp_valid = 1'b1; cmp_dst = {IW'(d1), IW'(d0)}; cmp_dst_vld = {v1, v0};
    @(negedge clk);
    cmp_valid = 1'b0;
    cyc = 0;
    while (busy && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  // Accept everything pending; return the emitted set, checking order and uniqueness.
  task automatic drain(input string tag, output int mask);
    int prev = -1;
    mask = 0;
    rdy_ready = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (rdy_valid) begin
        if (((mask >> rdy_cons) & 1) != 0 || int'(rdy_cons) <= prev)
          chk(1'b0, {tag, " order/once"}, int'(rdy_cons), prev + 1);
        mask |= (1 << rdy_cons);
        prev = int'(rdy_cons);
      end
      @(negedge clk);
    end
    rdy_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc, m;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sb_rdy == 16'hFFFF, "R1 scoreboard", int'(sb_rdy), 16'hFFFF);
    chk(!busy, "R1 busy", int'(busy), 0);
    chk(!rdy_valid, "R1 rdy_valid", int'(rdy_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R5/R6/R10: every register with one linked consumer
    for (int p = 0; p < NP; p++) begin
      do_alloc(p);
      chk(sb_rdy == 16'(~(32'h1 << p)), "R2 alloc clears one bit", int'(sb_rdy), int'(16'(~(32'h1 << p))));
      do_reg(p % 8, 1'b1, 1, p);
      chk(!rdy_valid, "R5 linked consumer waits", int'(rdy_valid), 0);
      do_cmp(p, 1'b1, 0, 1'b0, cyc);
      chk(cyc == 3, "R10 walk length one entry", cyc, 3);
      chk(sb_rdy[p], "R6 bit set after walk", int'(sb_rdy[p]), 1);
      drain("R5", m);
      chk(m == (1 << (p % 8)), "R5 woken consumer", m, 1 << (p % 8));
    end

    // R2: out-of-range allocation ignored
    for (int p = NP; p < 32; p++) begin
      do_alloc(p);
      chk(sb_rdy == 16'hFFFF, "R2 out-of-range alloc", int'(sb_rdy), 16'hFFFF);
    end

    // R4: out-of-range destination and invalid slot
    do_cmp(20, 1'b1, 0, 1'b0, cyc);
    chk(cyc == 2, "R4 skip length", cyc, 2);
    chk(sb_rdy == 16'hFFFF, "R4 out-of-range dst", int'(sb_rdy), 16'hFFFF);
    do_alloc(5);
    do_cmp(5, 1'b0, 5, 1'b0, cyc);
    chk(sb_rdy[5] == 1'b0, "R4 invalid slot ignored", int'(sb_rdy[5]), 0);
    do_cmp(5, 1'b1, 0, 1'b0, cyc);

    // R5/R9/R10: six consumers on one register
    do_alloc(3);
    for (int c = 0; c < 6; c++) do_reg(c, 1'b1, 1, 3);
    do_cmp(3, 1'b1, 0, 1'b0, cyc);
    chk(cyc == 8, "R10 walk length six entries", cyc, 8);
    drain("R9", m);
    chk(m == 6'h3F, "R9 all six emitted", m, 6'h3F);

    // R6: list empty after drain
    do_alloc(3);
    do_cmp(3, 1'b1, 0, 1'b0, cyc);
    chk(cyc == 2, "R6 empty list walk", cyc, 2);
    chk(!rdy_valid, "R6 no second wake", int'(rdy_valid), 0);

    // R8: two sources on different registers
    do_alloc(4); do_alloc(5);
    do_reg(0, 1'b1, 2, 4);
    do_reg(0, 1'b0, 0, 5);
    do_cmp(4, 1'b1, 0, 1'b0, cyc);
    chk(!rdy_valid, "R8 one of two sources", int'(rdy_valid), 0);
    do_cmp(5, 1'b1, 0, 1'b0, cyc);
    drain("R8", m);
    chk(m == 1, "R8 both sources woken", m, 1);

    // R8: two sources on one register
    do_alloc(6);
    do_reg(1, 1'b1, 2, 6);
    do_reg(1, 1'b0, 0, 6);
    do_cmp(6, 1'b1, 0, 1'b0, cyc);
    chk(cyc == 4, "R8 same-register walk", cyc, 4);
    drain("R8", m);
    chk(m == 2, "R8 same-register emitted once", m, 2);

    // R7: ready source decrements immediately, no link
    do_reg(2, 1'b1, 1, 7);
    chk(rdy_valid && rdy_cons == 3'd2, "R7 immediate ready", int'(rdy_cons), 2);
    drain("R7", m);
    do_reg(3, 1'b1, 1, 25);
    drain("R7", m);
    chk(m == 8, "R7 out-of-range source", m, 8);
    do_alloc(7);
    do_cmp(7, 1'b1, 0, 1'b0, cyc);
    chk(cyc == 2, "R7 nothing linked", cyc, 2);

    // R11: same-cycle allocate and register
    alc_valid = 1'b1; alc_preg = 5'd11;
    do_reg(3, 1'b1, 1, 11);
    alc_valid = 1'b0;
    chk(!rdy_valid, "R11 treated not ready", int'(rdy_valid), 0);
    do_cmp(11, 1'b1, 0, 1'b0, cyc);
    chk(cyc == 3, "R11 linked", cyc, 3);
    drain("R11", m);
    chk(m == 8, "R11 emitted after wake", m, 8);

    // R4/R10: both slots valid
    do_alloc(12); do_alloc(13);
    do_reg(4, 1'b1, 1, 12);
    do_reg(5, 1'b1, 1, 13);
    do_cmp(12, 1'b1, 13, 1'b1, cyc);
    chk(cyc == 4, "R10 two-slot walk", cyc, 4);
    drain("R5", m);
    chk(m == 8'h30, "R5 two-slot wake", m, 8'h30);

    // R3: inputs during busy are ignored
    do_alloc(3);
    for (int c = 0; c < 3; c++) do_reg(c, 1'b1, 1, 3);
    cmp_valid = 1'b1; cmp_dst = {5'd0, 5'd3}; cmp_dst_vld = 2'b01;
    @(negedge clk);
    chk(busy, "R3 busy after accept", int'(busy), 1);
    cmp_dst = {5'd0, 5'd14};
    alc_valid = 1'b1; alc_preg = 5'd9;
    reg_valid = 1'b1; reg_cons = 3'd7; reg_first = 1'b1; reg_nsrc = 2'd1; reg_preg = 5'd10;
    @(negedge clk);
    cmp_valid = 1'b0; alc_valid = 1'b0; reg_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R3 completion while busy dropped", int'(busy), 0);
    chk(sb_rdy == 16'hFFFF, "R3 alloc while busy dropped", int'(sb_rdy), 16'hFFFF);
    drain("R3", m);
    chk(m == 7, "R3 registration while busy dropped", m, 7);

    // R9: valid held while not accepted, lowest first
    do_alloc(8);
    do_reg(6, 1'b1, 1, 8);
    do_reg(2, 1'b1, 1, 8);
    do_cmp(8, 1'b1, 0, 1'b0, cyc);
    for (int i = 0; i < 3; i++) begin
      chk(rdy_valid && rdy_cons == 3'd2, "R9 hold lowest", int'(rdy_cons), 2);
      @(negedge clk);
    end
    drain("R9", m);
    chk(m == 8'h44, "R9 both emitted", m, 8'h44);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule